// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a synthesizable, clock-sampled model of a 32-bit-wide asynchronous static memory. A controller drives pin-level strobes: three active-low chip selects, a write strobe, an output strobe and four active-low lane strobes, one per byte. Writes store only the bytes whose lane strobe is low. Reads present the stored word on a data output together with a per-lane drive-enable vector; a lane whose enable bit is low stands for a high-impedance byte, and a wrapping pad ring would use the vector to control its tristate drivers.

Asynchronous behaviour is emulated on a clock. A write window is open in every cycle where all selects are low and the write strobe is low. Address, data and lane strobes are captured in each such cycle, and the values from the last open cycle are committed when the window closes, whichever signal closes it. Read data is shown once a read request has been held with a steady address for a configurable number of clock edges. The address width is a parameter; 19 bits gives 524,288 words. The default is narrower so that the storage stays small when the block is elaborated alone. All pins are plain level signals with no valid/ready handshake, so there is no back-pressure: a controller holds its strobes for as long as an access needs.

Top module: `bytelane_sram`

## Requirements
- R1: Storage holds 2^ADDR_W words of 32 bits, addressed by `addr`. Each word keeps its value until a write commits to it.
- R2: Any `sel_n` bit high blocks both writing and driving. While any select is high, `drive_en` is 0 and no memory word changes.
- R3: A write commits only the lanes whose `lane_n` bit was low in the last open cycle of the window. Other lanes, and every other word, keep their contents. A window with all four `lane_n` bits high changes nothing.
- R4: While a write window is open (all `sel_n` low and `wr_n` low), `drive_en` is 0.
- R5: `drive_en` is 0 whenever `oe_n` is high or all four `lane_n` bits are high.
- R6: Lane i carries data bits 8*i+7:8*i for both writes and reads: `lane_n[0]` covers bits 7:0, `lane_n[1]` 15:8, `lane_n[2]` 23:16, `lane_n[3]` 31:24. During a served read, `drive_en` equals the inverse of `lane_n`, and each enabled byte of `rdata` equals the stored byte.
- R7: A read request is all `sel_n` low, `wr_n` high, `oe_n` low and at least one `lane_n` bit low. It is served once the request has been held with an unchanged `addr` across RD_LAT rising edges. An address change or a dropped request makes `drive_en` 0 at once, and the count starts again.
- R8: Bytes of `rdata` whose `drive_en` bit is 0 read as zero. After reset, `drive_en` is 0.
- R9: A write window ends on the first cycle in which any select goes high or `wr_n` goes high. The address, data and lanes captured in the last open cycle are committed, and the memory holds them from the first rising edge after the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address |
| sel_n | input | 3 | Active-low chip selects; all must be low |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| lane_n | input | 4 | Active-low byte-lane strobes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; undriven bytes are zero |
| drive_en | output | 4 | Per-lane bus drive enable; 0 means high impedance |

## Verification
The checker watches the float rules on every cycle: no drive with a select high, during an open write window, with the output strobe high, or on a lane whose strobe is high. It also checks that a driven read always follows a request held at the same address, and that undriven bytes read as zero. Whether committed bytes are correct, that masked lanes are preserved, which edge ends a write window, and that a blocked write leaves memory unchanged can only be shown by the bench. It does this by reading every lane back against its own shadow model of the memory.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int SELS   = 3;
  typedef logic [LANES-1:0]  lane_vec_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
(
  input  logic [SELS-1:0] sel_n,
  input  logic            wr_n,
  input  logic            oe_n,
  input  lane_vec_t       lane_n,
  output logic            wr_open,
  output logic            rd_req
);
  logic chip_on;
  assign chip_on = ~|sel_n;
  assign wr_open = chip_on & ~wr_n;
  assign rd_req  = chip_on & wr_n & ~oe_n & ~&lane_n;
endmodule

// File: rtl/bls_write_capture.sv
module bls_write_capture
  import bls_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_open,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  input  lane_vec_t         lane_n,
  output logic              commit,
  output logic [ADDR_W-1:0] cap_addr,
  output word_t             cap_data,
  output lane_vec_t         cap_lanes
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
      cap_lanes <= '0;
    end else begin
      open_q <= wr_open;
      if (wr_open) begin
        cap_addr  <= addr;
        cap_data  <= wdata;
        cap_lanes <= ~lane_n;
      end
    end
  end

  // the window closed in this cycle: commit what the last open cycle held
  assign commit = open_q & ~wr_open;
endmodule

// File: rtl/bls_lane_array.sv
module bls_lane_array
  import bls_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              commit,
  input  logic [ADDR_W-1:0] waddr,
  input  word_t             wword,
  input  lane_vec_t         wlanes,
  input  logic [ADDR_W-1:0] raddr,
  output word_t             rword
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (commit && wlanes[g]) cells[waddr] <= wword[g*LANE_W +: LANE_W];
    end
    assign rword[g*LANE_W +: LANE_W] = cells[raddr];
  end
endmodule

// File: rtl/bls_read_timer.sv
module bls_read_timer #(
  parameter int ADDR_W = 10,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  output logic              ready
);
  localparam int CNT_W = $clog2(RD_LAT + 1);
  localparam logic [CNT_W-1:0] LAT = CNT_W'(RD_LAT);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic              req_q;
  logic              fresh;

  assign fresh = rd_req & (~req_q | (addr != addr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      addr_q <= '0;
      req_q  <= 1'b0;
    end else begin
      req_q  <= rd_req;
      addr_q <= addr;
      if (!rd_req)        cnt <= '0;
      else if (fresh)     cnt <= CNT_W'(1);
      else if (cnt < LAT) cnt <= cnt + CNT_W'(1);
    end
  end

  assign ready = rd_req & ~fresh & (cnt >= LAT);
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [3:0]        lane_n,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [3:0]        drive_en
);
  logic              wr_open, rd_req, commit, ready;
  logic [ADDR_W-1:0] cap_addr;
  word_t             cap_data, rword;
  lane_vec_t         cap_lanes;

  bls_decode u_decode (
    .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n), .lane_n(lane_n),
    .wr_open(wr_open), .rd_req(rd_req)
  );

  bls_write_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .addr(addr),
    .wdata(wdata), .lane_n(lane_n), .commit(commit),
    .cap_addr(cap_addr), .cap_data(cap_data), .cap_lanes(cap_lanes)
  );

  bls_lane_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .commit(commit), .waddr(cap_addr), .wword(cap_data),
    .wlanes(cap_lanes), .raddr(addr), .rword(rword)
  );

  bls_read_timer #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .addr(addr), .ready(ready)
  );

  always_comb begin
    drive_en = ready ? ~lane_n : 4'b0000;
    for (int i = 0; i < LANES; i++) begin
      rdata[i*LANE_W +: LANE_W] = drive_en[i] ? rword[i*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/bytelane_sram_checker.sv
module bytelane_sram_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        sel_n,
  input logic              wr_n,
  input logic              oe_n,
  input logic [3:0]        lane_n,
  input logic [31:0]       rdata,
  input logic [3:0]        drive_en
);
  logic req_now;
  assign req_now = (sel_n == 3'b000) && wr_n && !oe_n && (lane_n != 4'hF);

  a_r2_float_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n != 3'b000) |-> (drive_en == 4'b0000));

  a_r4_float_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_n == 3'b000) && !wr_n) |-> (drive_en == 4'b0000));

  a_r5_float_oe_or_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || (lane_n == 4'hF)) |-> (drive_en == 4'b0000));

  a_r6_drive_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en != 4'b0000) |-> ((drive_en & lane_n) == 4'b0000));

  a_r7_drive_after_held_req: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en != 4'b0000) |-> ($past(req_now) && ($past(addr) == addr)));

  a_r8_undriven_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata[7:0]   == 8'h00) || drive_en[0]) &&
    ((rdata[15:8]  == 8'h00) || drive_en[1]) &&
    ((rdata[23:16] == 8'h00) || drive_en[2]) &&
    ((rdata[31:24] == 8'h00) || drive_en[3]));
endmodule

bind bytelane_sram bytelane_sram_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
  .oe_n(oe_n), .lane_n(lane_n), .rdata(rdata), .drive_en(drive_en)
);

// File: tb/bytelane_sram_bench.sv
module bytelane_sram_bench;
  localparam int ADDR_W = 10;
  localparam int RD_LAT = 2;

  typedef struct {
    logic [3:0]  drv;
    logic [31:0] data;
    string       tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [2:0]        sel_n = 3'b111;
  logic              wr_n = 1'b1;
  logic              oe_n = 1'b1;
  logic [3:0]        lane_n = 4'hF;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [3:0]        drive_en;

  int checks = 0;
  int errors = 0;
  logic mon_req = 1'b0;
  item_t exp_q[$];
  logic [31:0] shadow [int];

  always #2 clk = ~clk;

  bytelane_sram #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_bytelane_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
    .oe_n(oe_n), .lane_n(lane_n), .wdata(wdata), .rdata(rdata), .drive_en(drive_en)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] ln);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = ln[i] ? 8'h00 : 8'hFF;
    return m;
  endfunction

  task automatic idle();
    sel_n = 3'b111; wr_n = 1'b1; oe_n = 1'b1; lane_n = 4'hF;
  endtask

  // Driver: write window of len cycles; checks float in the window (R4)
  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          input logic [3:0] ln, input int len);
    @(negedge clk);
    addr = a; wdata = d; lane_n = ln; sel_n = 3'b000; wr_n = 1'b0; oe_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      check(drive_en == 4'b0000, "R4 float in write window", {28'd0, drive_en}, 32'd0);
    end
    @(negedge clk);
    idle();
    if (ln != 4'hF) begin
      if (!shadow.exists(int'(a))) shadow[int'(a)] = 32'd0;
      shadow[int'(a)] = (shadow[int'(a)] & ~lane_mask(ln)) | (d & lane_mask(ln));
    end
  endtask

  // Driver: read; pushes expected item, checks no early drive (R7)
  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [3:0] ln, input string tag);
    item_t it;
    it.drv  = ~ln;
    it.data = shadow[int'(a)] & lane_mask(ln);
    it.tag  = tag;
    @(negedge clk);
    addr = a; lane_n = ln; sel_n = 3'b000; wr_n = 1'b1; oe_n = 1'b0;
    exp_q.push_back(it);
    repeat (RD_LAT - 1) @(posedge clk);
    #1;
    check(drive_en == 4'b0000, "R7 no drive before latency", {28'd0, drive_en}, 32'd0);
    mon_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mon_req = 1'b0;
    idle();
  endtask

  // Monitor: pops the expected item at the serving edge
  always @(posedge clk) begin
    if (mon_req) begin
      item_t it;
      #1;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 monitor queue empty", 32'd0, 32'd0);
      end else begin
        it = exp_q.pop_front();
        check(drive_en == it.drv, {it.tag, " R6 drive_en"}, {28'd0, drive_en}, {28'd0, it.drv});
        check(rdata == it.data, {it.tag, " R6 R8 rdata"}, rdata, it.data);
      end
    end
  end

  // hold a would-be read for several cycles and require no drive
  task automatic hold_no_drive(input logic [ADDR_W-1:0] a, input logic [2:0] s,
                               input logic o, input logic [3:0] ln, input string tag);
    @(negedge clk);
    addr = a; sel_n = s; wr_n = 1'b1; oe_n = o; lane_n = ln;
    repeat (RD_LAT + 2) @(posedge clk);
    #1;
    check(drive_en == 4'b0000, tag, {28'd0, drive_en}, 32'd0);
    check(rdata == 32'd0, {tag, " R8 zero"}, rdata, 32'd0);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(drive_en == 4'b0000, "R8 reset drive_en", {28'd0, drive_en}, 32'd0);
    check(rdata == 32'd0, "R8 reset rdata", rdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: fill a spread of addresses, including both ends
    for (int i = 0; i < 16; i++) begin
      logic [ADDR_W-1:0] a;
      a = (i == 15) ? {ADDR_W{1'b1}} : ADDR_W'(i * 61);
      do_write(a, 32'hA5000000 ^ (i * 32'h01010101) ^ 32'h00C3_3C00, 4'h0, 1 + (i % 3));
    end
    for (int i = 0; i < 16; i++) begin
      logic [ADDR_W-1:0] a;
      a = (i == 15) ? {ADDR_W{1'b1}} : ADDR_W'(i * 61);
      do_read(a, 4'h0, "R1 full word");
    end

    // R3 R6: random-mask writes, then every lane read back
    for (int k = 0; k < 40; k++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(($urandom % 16) * 61);
      do_write(a, $urandom, 4'($urandom), 1 + ($urandom % 3));
      do_read(a, 4'h0, "R3 masked write");
      do_read(a, 4'($urandom % 15), "R6 partial lanes");
    end

    // R3: all lanes off leaves word intact
    do_write(ADDR_W'(61), 32'hDEADBEEF, 4'hF, 2);
    do_read(ADDR_W'(61), 4'h0, "R3 no-lane write");

    // R6: single-lane mapping
    do_write(ADDR_W'(122), 32'h44332211, 4'h0, 1);
    for (int i = 0; i < 4; i++) do_read(ADDR_W'(122), ~(4'b0001 << i), "R6 single lane");

    // R2: write blocked by each select in turn
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      addr = ADDR_W'(183); wdata = 32'h0BAD0BAD; lane_n = 4'h0;
      sel_n = 3'b001 << s; wr_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      check(drive_en == 4'b0000, "R2 no drive while deselected", {28'd0, drive_en}, 32'd0);
      @(negedge clk);
      idle();
      do_read(ADDR_W'(183), 4'h0, "R2 blocked write");
      hold_no_drive(ADDR_W'(183), 3'b001 << s, 1'b0, 4'h0, "R2 deselected read");
    end

    // R5: output strobe high, all lanes off
    hold_no_drive(ADDR_W'(183), 3'b000, 1'b1, 4'h0, "R5 oe high");
    hold_no_drive(ADDR_W'(183), 3'b000, 1'b0, 4'hF, "R5 all lanes off");

    // R9: window closed by a select; last open cycle's values commit
    @(negedge clk);
    addr = ADDR_W'(244); wdata = 32'h11111111; lane_n = 4'h0; sel_n = 3'b000; wr_n = 1'b0;
    @(negedge clk);
    addr = ADDR_W'(305); wdata = 32'h5A5A1234; lane_n = 4'b1100;
    @(negedge clk);
    sel_n = 3'b010;
    wdata = 32'hFFFFFFFF; lane_n = 4'h0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    idle();
    shadow[305] = (shadow[305] & 32'hFFFF0000) | 32'h00001234;
    do_read(ADDR_W'(305), 4'h0, "R9 last cycle commit");
    do_read(ADDR_W'(244), 4'h0, "R9 earlier address untouched");

    // R7: address change mid-read restarts the latency
    @(negedge clk);
    addr = ADDR_W'(0); lane_n = 4'h0; sel_n = 3'b000; wr_n = 1'b1; oe_n = 1'b0;
    repeat (RD_LAT) @(posedge clk);
    #1;
    check(drive_en == 4'hF, "R7 served after latency", {28'd0, drive_en}, 32'h0000000F);
    @(negedge clk);
    addr = ADDR_W'(61);
    #1;
    check(drive_en == 4'h0, "R7 address change drops drive", {28'd0, drive_en}, 32'd0);
    @(negedge clk);
    idle();

    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R6 all reads observed", exp_q.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule